// File: doc/BRIEF.md
# Fracturable Dual-LUT Logic Cell

This block models one configurable logic cell of a programmable fabric. Eight data pins (`a`, `b`, `c`, `d`, `e0`, `f0`, `e1`, `f1`) feed a pair of 64-bit lookup masks. Depending on the mode, the masks act as two independent six-input functions, as narrower function pairs with fixed input sharing, as one seven-input function built from a 2:1 choice between two five-input functions, or as four four-input functions feeding two chained full adders. Two output registers sit behind the combinational results. Each register has an enable, an asynchronous clear, a synchronous clear and a synchronous load. The registered and the unregistered values are both visible at the ports.

A configuration word sets the mode, the two masks and the data source of each register. It is staged in one of two ways: it is presented in parallel, or it is shifted in one bit per clock into a shadow register. It takes effect only on a clock edge where the load strobe is high. A register chain runs from `chain_i` through register 0 and register 1 to `chain_o`. This chain forms a shift path that does not pass through the lookup masks.

Top module: `logic_cell`

## Requirements
- R1: The active configuration changes only on a rising clock edge with `cfg_load_i` high. On that edge it takes `cfg_par_i` when `cfg_src_i` is 0, or the serial shadow when `cfg_src_i` is 1. The shadow shifts left on each edge with `cfg_shift_i` high and takes `cfg_sdi_i` into bit 0. The word holds the following fields: mask0 at [63:0], mask1 at [127:64], reg0 source at [129:128], reg1 source at [131:130] and mode at [134:132]. Reset clears the active word and the shadow.
- R2: Mode 0 gives `comb_o[0]` = mask0[{f0,e0,d,c,b,a}] and `comb_o[1]` = mask1[{f1,e1,d,c,b,a}]. In each address, `a` is the least significant bit.
- R3: Mode 1 gives two five-input functions that share only `a` and `b`: `comb_o[0]` = mask0[{f0,e0,c,b,a}] and `comb_o[1]` = mask1[{f1,e1,d,b,a}].
- R4: Mode 2 gives two four-input functions with no shared input: `comb_o[0]` = mask0[{f0,e0,c,a}] and `comb_o[1]` = mask1[{f1,e1,d,b}].
- R5: Mode 3 sets `comb_o[0]` to mask1[{e1,d,c,b,a}] when `f0` is 1, and to mask0[{e0,d,c,b,a}] otherwise. `comb_o[1]` is 0. Register 1 clears on every edge, whatever its controls say. When register 0 selects its packed source, that source is `f1`.
- R6: Mode 4 uses two chained adders. Adder 0 adds mask0[{c,e0,b,a}], mask0[16+{c,f0,b,a}] and `carry_i`. Adder 1 adds mask1[{d,e1,b,a}], mask1[16+{d,f1,b,a}] and the carry out of adder 0. The two sums appear on `comb_o[1:0]`, and the carry out of adder 1 appears on `carry_o`.
- R7: In every mode other than 4, the adder inputs are held low, so `carry_o` is 0.
- R8: Mode 5 bypasses the lookup masks. `comb_o` is 0, register 0 takes its data from `chain_i` and register 1 takes its data from register 0, whatever the source fields say.
- R9: Mode codes 6 and 7 drive `comb_o` to 0. The registers then follow their source fields, taking 0 as the combinational value.
- R10: For register k, a high `aclr_i[k]` clears it at once. Otherwise, on an edge with `ce_i[k]` high, `sclr_i[k]` clears it, else `sload_i[k]` loads `sdata_i[k]`, else it takes its selected data. With `ce_i[k]` low it holds its value.
- R11: A register source field selects the data as follows. 0 or 3 selects the register's own combinational result. 1 selects a packed pin: `e0` for register 0 and `f1` for register 1. 2 selects the chain: `chain_i` for register 0 and the register 0 output for register 1.
- R12: `chain_o` always equals `q_o[1]`. After reset, `q_o`, `comb_o`, `carry_o` and `chain_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_shift_i | input | 1 | Shifts the serial shadow by one bit |
| cfg_sdi_i | input | 1 | Serial configuration data bit |
| cfg_load_i | input | 1 | Applies a configuration on this edge |
| cfg_src_i | input | 1 | Load source: 0 parallel, 1 shadow |
| cfg_par_i | input | 135 | Parallel configuration word |
| data_i | input | 8 | {f1,e1,f0,e0,d,c,b,a} |
| carry_i | input | 1 | Carry into adder 0 |
| chain_i | input | 1 | Register chain input |
| ce_i | input | 2 | Per-register clock enable |
| aclr_i | input | 2 | Per-register asynchronous clear |
| sclr_i | input | 2 | Per-register synchronous clear |
| sload_i | input | 2 | Per-register synchronous load |
| sdata_i | input | 2 | Synchronous load data |
| comb_o | output | 2 | Unregistered results |
| q_o | output | 2 | Register outputs |
| carry_o | output | 1 | Carry out of adder 1 |
| chain_o | output | 1 | Register chain output |

## Verification
Each of the eight mode codes is loaded with random masks and random source fields. The cell then runs on random data pins, so that every mode's address wiring is told apart: a pin placed at the wrong address position disagrees with the reference on roughly half the patterns. The parallel word keeps changing while the load strobe is low, and the serial shadow keeps shifting, which shows that only a strobed edge changes the behaviour. A full configuration is also shifted in serially and applied, which shows the bit order of the shadow. Rare synchronous clears and loads exercise the control priority on top of the random data. A directed asynchronous clear between edges shows that the register outputs drop before the next edge.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LUT_K  = 6;
  localparam int MASK_W = 1 << LUT_K;
  localparam int N_REG  = 2;

  typedef enum logic [2:0] {
    MODE_N6    = 3'd0,
    MODE_N5    = 3'd1,
    MODE_N4    = 3'd2,
    MODE_EXT7  = 3'd3,
    MODE_ARITH = 3'd4,
    MODE_SHIFT = 3'd5
  } mode_e;

  typedef enum logic [1:0] {
    SRC_COMB  = 2'd0,
    SRC_PACK  = 2'd1,
    SRC_CHAIN = 2'd2,
    SRC_COMB2 = 2'd3
  } src_e;

  typedef struct packed {
    logic [2:0]        mode;
    logic [1:0]        src1;
    logic [1:0]        src0;
    logic [MASK_W-1:0] mask1;
    logic [MASK_W-1:0] mask0;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  typedef struct packed {
    logic f1;
    logic e1;
    logic f0;
    logic e0;
    logic d;
    logic c;
    logic b;
    logic a;
  } pins_t;
endpackage

// File: rtl/lc_cfg.sv
module lc_cfg
  import lc_pkg::*;
#(
  parameter int W = CFG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         sdi_i,
  input  logic         load_i,
  input  logic         src_i,
  input  logic [W-1:0] par_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (shift_i) shadow_q <= {shadow_q[W-2:0], sdi_i};
      // load uses the shadow as it was before this edge
      if (load_i)  active_q <= src_i ? shadow_q : par_i;
    end
  end

  assign cfg_o = active_q;
endmodule

// File: rtl/lc_func.sv
module lc_func
  import lc_pkg::*;
(
  input  logic [2:0]        mode_i,
  input  logic [MASK_W-1:0] mask0_i,
  input  logic [MASK_W-1:0] mask1_i,
  input  pins_t             pins_i,
  input  logic              carry_i,
  output logic [1:0]        comb_o,
  output logic              carry_o
);
  localparam int N_ADD = 2;

  logic             arith;
  logic [LUT_K-1:0] ad0, ad1;
  logic [1:0]       lut_res;
  logic [N_ADD-1:0] op_x, op_y, sum;
  logic [N_ADD:0]   cy;
  logic             ext_a, ext_b;

  assign arith = (mode_i == MODE_ARITH);

  always_comb begin
    ad0 = '0;
    ad1 = '0;
    unique case (mode_i)
      MODE_N6: begin
        ad0 = {pins_i.f0, pins_i.e0, pins_i.d, pins_i.c, pins_i.b, pins_i.a};
        ad1 = {pins_i.f1, pins_i.e1, pins_i.d, pins_i.c, pins_i.b, pins_i.a};
      end
      MODE_N5: begin
        ad0 = {1'b0, pins_i.f0, pins_i.e0, pins_i.c, pins_i.b, pins_i.a};
        ad1 = {1'b0, pins_i.f1, pins_i.e1, pins_i.d, pins_i.b, pins_i.a};
      end
      MODE_N4: begin
        ad0 = {2'b00, pins_i.f0, pins_i.e0, pins_i.c, pins_i.a};
        ad1 = {2'b00, pins_i.f1, pins_i.e1, pins_i.d, pins_i.b};
      end
      MODE_EXT7: begin
        ad0 = {1'b0, pins_i.e0, pins_i.d, pins_i.c, pins_i.b, pins_i.a};
        ad1 = {1'b0, pins_i.e1, pins_i.d, pins_i.c, pins_i.b, pins_i.a};
      end
      default: begin
        ad0 = '0;
        ad1 = '0;
      end
    endcase
  end

  assign lut_res = {mask1_i[ad1], mask0_i[ad0]};
  assign ext_a   = lut_res[0];
  assign ext_b   = lut_res[1];

  // pre-adder lookups; operands held low outside arithmetic mode
  assign op_x[0] = arith & mask0_i[{2'b00, pins_i.c, pins_i.e0, pins_i.b, pins_i.a}];
  assign op_y[0] = arith & mask0_i[{2'b01, pins_i.c, pins_i.f0, pins_i.b, pins_i.a}];
  assign op_x[1] = arith & mask1_i[{2'b00, pins_i.d, pins_i.e1, pins_i.b, pins_i.a}];
  assign op_y[1] = arith & mask1_i[{2'b01, pins_i.d, pins_i.f1, pins_i.b, pins_i.a}];
  assign cy[0]   = arith & carry_i;

  for (genvar k = 0; k < N_ADD; k++) begin : g_add
    assign sum[k]  = op_x[k] ^ op_y[k] ^ cy[k];
    assign cy[k+1] = (op_x[k] & op_y[k]) | (cy[k] & (op_x[k] ^ op_y[k]));
  end

  assign carry_o = cy[N_ADD];

  always_comb begin
    unique case (mode_i)
      MODE_N6, MODE_N5, MODE_N4: comb_o = lut_res;
      MODE_EXT7:                 comb_o = {1'b0, pins_i.f0 ? ext_b : ext_a};
      MODE_ARITH:                comb_o = sum;
      default:                   comb_o = 2'b00;
    endcase
  end
endmodule

// File: rtl/lc_reg.sv
module lc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic aclr_i,
  input  logic ce_i,
  input  logic sclr_i,
  input  logic sload_i,
  input  logic sdata_i,
  input  logic force_clr_i,
  input  logic d_i,
  output logic q_o
);
  logic q;

  always_ff @(posedge clk_i or negedge rst_ni or posedge aclr_i) begin
    if (!rst_ni)          q <= 1'b0;
    else if (aclr_i)      q <= 1'b0;
    else if (force_clr_i) q <= 1'b0;
    else if (ce_i) begin
      if (sclr_i)         q <= 1'b0;
      else if (sload_i)   q <= sdata_i;
      else                q <= d_i;
    end
  end

  assign q_o = q;
endmodule

// File: rtl/logic_cell.sv
module logic_cell
  import lc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_shift_i,
  input  logic             cfg_sdi_i,
  input  logic             cfg_load_i,
  input  logic             cfg_src_i,
  input  logic [CFG_W-1:0] cfg_par_i,
  input  logic [7:0]       data_i,
  input  logic             carry_i,
  input  logic             chain_i,
  input  logic [1:0]       ce_i,
  input  logic [1:0]       aclr_i,
  input  logic [1:0]       sclr_i,
  input  logic [1:0]       sload_i,
  input  logic [1:0]       sdata_i,
  output logic [1:0]       comb_o,
  output logic [1:0]       q_o,
  output logic             carry_o,
  output logic             chain_o
);
  cfg_t             cfg_q;
  logic [CFG_W-1:0] cfg_raw;
  pins_t            pins;
  logic [1:0]       comb;
  logic [N_REG-1:0] q;
  logic             shift_md, ext7_md;

  assign pins = pins_t'(data_i);

  lc_cfg #(.W(CFG_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(cfg_shift_i),
    .sdi_i  (cfg_sdi_i),
    .load_i (cfg_load_i),
    .src_i  (cfg_src_i),
    .par_i  (cfg_par_i),
    .cfg_o  (cfg_raw)
  );
  assign cfg_q = cfg_t'(cfg_raw);

  lc_func u_func (
    .mode_i (cfg_q.mode),
    .mask0_i(cfg_q.mask0),
    .mask1_i(cfg_q.mask1),
    .pins_i (pins),
    .carry_i(carry_i),
    .comb_o (comb),
    .carry_o(carry_o)
  );

  assign shift_md = (cfg_q.mode == MODE_SHIFT);
  assign ext7_md  = (cfg_q.mode == MODE_EXT7);

  for (genvar k = 0; k < N_REG; k++) begin : g_reg
    logic [1:0] src;
    logic       pack_pin, chain_src, d;

    assign src = (k == 0) ? cfg_q.src0 : cfg_q.src1;
    if (k == 0) begin : g_first
      assign pack_pin  = ext7_md ? pins.f1 : pins.e0;
      assign chain_src = chain_i;
    end else begin : g_next
      assign pack_pin  = pins.f1;
      assign chain_src = q[k-1];
    end

    always_comb begin
      if (shift_md) d = chain_src;
      else begin
        unique case (src_e'(src))
          SRC_PACK:  d = pack_pin;
          SRC_CHAIN: d = chain_src;
          default:   d = comb[k];
        endcase
      end
    end

    lc_reg u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .aclr_i     (aclr_i[k]),
      .ce_i       (ce_i[k]),
      .sclr_i     (sclr_i[k]),
      .sload_i    (sload_i[k]),
      .sdata_i    (sdata_i[k]),
      .force_clr_i(ext7_md && (k == 1)),
      .d_i        (d),
      .q_o        (q[k])
    );
  end

  assign comb_o  = comb;
  assign q_o     = q;
  assign chain_o = q[N_REG-1];
endmodule

// File: rtl/lc_chk.sv
module lc_chk
  import lc_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cfg_load_i,
  input cfg_t       cfg_q,
  input logic       chain_i,
  input logic [1:0] ce_i,
  input logic [1:0] aclr_i,
  input logic [1:0] sclr_i,
  input logic [1:0] sload_i,
  input logic [1:0] comb_o,
  input logic [1:0] q_o,
  input logic       carry_o
);
  // R1
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_load_i |=> $stable(cfg_q));

  // R7
  carry_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode != MODE_ARITH) |-> !carry_o);

  // R9
  bad_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == 3'd6 || cfg_q.mode == 3'd7) |-> (comb_o == 2'b00));

  // R5
  ext7_reg1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_EXT7) |=> !q_o[1]);

  // R10
  sclr0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i[0] && sclr_i[0]) |=> !q_o[0]);

  // R8
  shift_path_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mode == MODE_SHIFT && ce_i[0] && !sclr_i[0] && !sload_i[0] && !aclr_i[0])
      |=> (q_o[0] == $past(chain_i)) || aclr_i[0]);
endmodule

bind logic_cell lc_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cfg_load_i(cfg_load_i),
  .cfg_q     (cfg_q),
  .chain_i   (chain_i),
  .ce_i      (ce_i),
  .aclr_i    (aclr_i),
  .sclr_i    (sclr_i),
  .sload_i   (sload_i),
  .comb_o    (comb_o),
  .q_o       (q_o),
  .carry_o   (carry_o)
);

// File: tb/sim_logic_cell.sv
`timescale 1ns/1ps
module sim_logic_cell;
  import lc_pkg::*;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             cfg_shift_i, cfg_sdi_i, cfg_load_i, cfg_src_i;
  logic [CFG_W-1:0] cfg_par_i;
  logic [7:0]       data_i;
  logic             carry_i, chain_i;
  logic [1:0]       ce_i, aclr_i, sclr_i, sload_i, sdata_i;
  logic [1:0]       comb_o, q_o;
  logic             carry_o, chain_o;

  logic [CFG_W-1:0] m_cfg, m_shadow;
  logic [1:0]       m_q;
  int               n_run = 0, n_fail = 0;
  bit               done = 0;
  string            tag_ovr = "";

  always #10 clk_i = ~clk_i;

  logic_cell u0 (.*);

  task automatic check(string req, logic [3:0] act, logic [3:0] exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  function automatic string req_of(int md);
    case (md)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      default: return "R9";
    endcase
  endfunction

  // reference: returns {carry, comb1, comb0}
  function automatic logic [2:0] ref_comb(logic [CFG_W-1:0] c, logic [7:0] x, logic cin);
    logic [63:0] k0, k1;
    int a, b, cc, d, e0, f0, e1, f1, md, s0, s1;
    k0 = c[63:0]; k1 = c[127:64]; md = c[134:132];
    a = x[0]; b = x[1]; cc = x[2]; d = x[3]; e0 = x[4]; f0 = x[5]; e1 = x[6]; f1 = x[7];
    case (md)
      0: return {1'b0, k1[a+2*b+4*cc+8*d+16*e1+32*f1], k0[a+2*b+4*cc+8*d+16*e0+32*f0]};
      1: return {1'b0, k1[a+2*b+4*d+8*e1+16*f1], k0[a+2*b+4*cc+8*e0+16*f0]};
      2: return {1'b0, k1[b+2*d+4*e1+8*f1], k0[a+2*cc+4*e0+8*f0]};
      3: return {2'b00, f0 ? k1[a+2*b+4*cc+8*d+16*e1] : k0[a+2*b+4*cc+8*d+16*e0]};
      4: begin
        s0 = k0[a+2*b+4*e0+8*cc] + k0[16+a+2*b+4*f0+8*cc] + cin;
        s1 = k1[a+2*b+4*e1+8*d] + k1[16+a+2*b+4*f1+8*d] + s0 / 2;
        return {s1 >= 2, s1[0], s0[0]};
      end
      default: return 3'b000;
    endcase
  endfunction

  // one clock: compare comb outputs, step the model across the edge, compare registers
  task automatic tick();
    logic [2:0] rc;
    logic [1:0] nq, dsel;
    int md;
    string t;
    #2;
    md = m_cfg[134:132];
    rc = ref_comb(m_cfg, data_i, carry_i);
    t = (tag_ovr != "") ? tag_ovr : req_of(md);
    check(t, {2'b00, comb_o}, {2'b00, rc[1:0]}, "comb");
    check("R7", {3'b000, carry_o}, {3'b000, (md == 4) ? rc[2] : 1'b0}, "carry");
    // data selection per R11 / R8 / R5
    for (int k = 0; k < 2; k++) begin
      logic [1:0] s;
      logic pk, ch;
      s  = (k == 0) ? m_cfg[129:128] : m_cfg[131:130];
      pk = (k == 0) ? ((md == 3) ? data_i[7] : data_i[4]) : data_i[7];
      ch = (k == 0) ? chain_i : m_q[0];
      if (md == 5)       dsel[k] = ch;
      else if (s == 2'd1) dsel[k] = pk;
      else if (s == 2'd2) dsel[k] = ch;
      else               dsel[k] = rc[k];
    end
    for (int k = 0; k < 2; k++) begin
      if (md == 3 && k == 1) nq[k] = 1'b0;
      else if (!ce_i[k])     nq[k] = m_q[k];
      else if (sclr_i[k])    nq[k] = 1'b0;
      else if (sload_i[k])   nq[k] = sdata_i[k];
      else                   nq[k] = dsel[k];
      if (aclr_i[k])         nq[k] = 1'b0;
    end
    @(posedge clk_i);
    m_q = nq;
    if (cfg_load_i)  m_cfg = cfg_src_i ? m_shadow : cfg_par_i;
    if (cfg_shift_i) m_shadow = {m_shadow[CFG_W-2:0], cfg_sdi_i};
    #2;
    check((md == 5) ? "R8" : "R11", {2'b00, q_o}, {2'b00, m_q}, "q");
    check("R12", {3'b000, chain_o}, {3'b000, m_q[1]}, "chain");
    @(negedge clk_i);
  endtask

  task automatic rand_pins();
    data_i      = 8'($urandom);
    carry_i     = 1'($urandom);
    chain_i     = 1'($urandom);
    ce_i        = {($urandom % 4) != 0, ($urandom % 4) != 0};
    sclr_i      = {($urandom % 10) == 0, ($urandom % 10) == 0};
    sload_i     = {($urandom % 8) == 0, ($urandom % 8) == 0};
    sdata_i     = 2'($urandom);
    cfg_shift_i = 1'($urandom);
    cfg_sdi_i   = 1'($urandom);
    cfg_par_i   = {3'($urandom), 4'($urandom), 32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
    cfg_load_i  = 1'b0;
    cfg_src_i   = 1'($urandom);
  endtask

  function automatic logic [CFG_W-1:0] rand_cfg(int md);
    return {3'(md), 4'($urandom), 32'($urandom), 32'($urandom), 32'($urandom), 32'($urandom)};
  endfunction

  initial begin
    logic [CFG_W-1:0] word;
    rst_ni = 1'b0;
    cfg_shift_i = 0; cfg_sdi_i = 0; cfg_load_i = 0; cfg_src_i = 0; cfg_par_i = '0;
    data_i = 8'hff; carry_i = 1; chain_i = 1;
    ce_i = 2'b11; aclr_i = 2'b00; sclr_i = 0; sload_i = 0; sdata_i = 2'b11;
    m_cfg = '0; m_shadow = '0; m_q = 2'b00;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check("R12", {q_o, comb_o}, 4'b0000, "reset q/comb");
    check("R12", {2'b00, carry_o, chain_o}, 4'b0000, "reset carry/chain");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int md = 0; md < 8; md++) begin
      rand_pins();
      cfg_par_i  = rand_cfg(md);
      cfg_src_i  = 1'b0;
      cfg_load_i = 1'b1;
      tag_ovr = "R1";
      tick();
      tag_ovr = "";
      repeat (60) begin
        rand_pins();
        tick();
      end
    end

    // R1 serial path: shift a full word in, then apply it
    word = rand_cfg(4);
    for (int i = CFG_W - 1; i >= 0; i--) begin
      rand_pins();
      cfg_shift_i = 1'b1;
      cfg_sdi_i   = word[i];
      tick();
    end
    rand_pins();
    cfg_shift_i = 1'b0;
    cfg_src_i   = 1'b1;
    cfg_load_i  = 1'b1;
    tick();
    check("R1", {1'b0, m_cfg[134:132]}, 4'd4, "serial mode");
    tag_ovr = "R1";
    repeat (30) begin
      rand_pins();
      tick();
    end
    tag_ovr = "";

    // R10 async clear between edges
    rand_pins();
    cfg_par_i = rand_cfg(0); cfg_src_i = 0; cfg_load_i = 1;
    tick();
    rand_pins();
    ce_i = 2'b11; sclr_i = 0; sload_i = 2'b11; sdata_i = 2'b11;
    tick();
    check("R10", {2'b00, q_o}, 4'b0011, "sload set");
    aclr_i = 2'b11;
    #2;
    m_q = 2'b00;
    check("R10", {2'b00, q_o}, 4'b0000, "async clear");
    rand_pins();
    tick();
    aclr_i = 2'b00;
    repeat (10) begin
      rand_pins();
      tick();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule